// File: doc/BRIEF.md
# Sleep and Wakeup Power Sequencer

This block puts a small microcontroller to sleep and brings it back. Firmware sets a sleep control bit with a one-cycle write strobe. The block then asks the CPU for the bus. Once the CPU grants the bus, the block drives a chip-wide power-down line on the next falling edge of the CPU clock. The fast clock is treated as stopped from that point on.

While asleep, the block watches the pending and enable vectors of the interrupt lines. Any line that is both pending and enabled starts the wakeup. The wakeup runs on a slow 32 kHz clock, alternating its falling and rising edges:
1. A falling edge captures the interrupt.
2. The next rising edge releases power-down.
3. The rising edge after that raises a one-period strobe that samples the supply supervisors.
4. The falling edge after that returns the bus to the CPU.

An unmasked interrupt that arrives while the bus is still only requested cancels the sleep attempt.

The CPU-domain machine has three states:
- `C_AWAKE` goes to `C_REQ` on a sleep write.
- `C_REQ` goes back to `C_AWAKE` on a synchronized interrupt (cancel), or to `C_DOWN` on bus grant.
- `C_DOWN` goes to `C_AWAKE` once the synchronized bus-release flag is seen.

The slow-domain machine has five states:
- `S_IDLE` goes to `S_ASLEEP` when the synchronized power-down is seen.
- `S_ASLEEP` goes to `S_PWRUP` on a captured interrupt.
- `S_PWRUP` goes to `S_SAMPLE`.
- `S_SAMPLE` goes to `S_DONE`.
- `S_DONE` goes to `S_IDLE` when the synchronized power-down has cleared.

Top module: `slp_wake_seq`

## Requirements
- R1: While the block is awake, `sleep_wr` high drives `bus_req` high in the same cycle, through logic only.
- R2: `pwr_dn` rises on the falling edge of `cpu_clk` that follows the rising edge at which `bus_ack` is seen in the requesting phase. It is still low in the half cycle after that rising edge.
- R3: `pwr_dn` is high only while `bus_req` is high.
- R4: A wake event is any `i` with `irq_pend[i] & irq_en[i]` equal to 1. Pending lines whose `irq_en` bit is 0 leave `pwr_dn` high and `phase` at 2.
- R5: A wake event is captured on a falling edge of `slow_clk`. `pwr_dn` stays high through that edge and falls on the next rising edge of `slow_clk`.
- R6: `sup_sample` is high for exactly one `slow_clk` period. It starts at the second rising edge of `slow_clk` after the capture.
- R7: `bus_req` falls on the falling edge of `slow_clk` that follows the rise of `sup_sample`. `pwr_dn` is low at that point.
- R8: Within eight `cpu_clk` cycles of the bus release, `sleep_bit` is 0 and `phase` is 0. The CPU has dropped `bus_ack` by then.
- R9: An unmasked interrupt that is present, once synchronized (two `cpu_clk` flops), before the grant is acted on returns the block to awake. It drops `bus_req` and clears `sleep_bit`, and `pwr_dn` never rises.
- R10: `phase` encodes the current phase:
  - 0: awake
  - 1: requesting (bus asked, power not yet down)
  - 2: powered down (`pwr_dn` high)
  - 3: waking (power back, sleep bit still set)
- R11: Reset leaves `bus_req`, `pwr_dn`, `sup_sample`, `sleep_bit` and `phase` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast CPU clock; stops while power is down |
| slow_clk | input | 1 | Free-running 32 kHz sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sleep_wr | input | 1 | One-cycle firmware write that sets the sleep bit |
| bus_ack | input | 1 | Bus grant from the CPU |
| irq_pend | input | N_IRQ | Interrupt pending lines |
| irq_en | input | N_IRQ | Per-line enable; 1 means unmasked |
| bus_req | output | 1 | Bus request to the CPU |
| pwr_dn | output | 1 | System-wide power-down |
| sup_sample | output | 1 | One slow-period strobe to sample reset and low-voltage supervisors |
| sleep_bit | output | 1 | Current value of the sleep bit |
| phase | output | 2 | Phase code as in R10 |

## Verification
A CPU machine left stuck in the requesting or down state shows up within one or two `cpu_clk` cycles. It appears as `bus_req` or `sleep_bit` staying high, or as `pwr_dn` rising without a grant or despite a cancel.

A slow machine that skips or repeats a step shifts the fall of `pwr_dn`, the strobe, or the bus release by one `slow_clk` edge. The bench samples each of these two nanoseconds after every slow edge of the sequence, so such a shift is reported at that very edge.

The sweep covers every combination of pending and enable on four lines. A wrong mask decode therefore shows as a missed or spurious wakeup within three slow periods.

// File: rtl/slpw_pkg.sv
package slpw_pkg;

    typedef enum logic [1:0] {
        C_AWAKE = 2'd0,
        C_REQ   = 2'd1,
        C_DOWN  = 2'd2
    } cpu_st_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ASLEEP = 3'd1,
        S_PWRUP  = 3'd2,
        S_SAMPLE = 3'd3,
        S_DONE   = 3'd4
    } slow_st_e;

    typedef enum logic [1:0] {
        PH_AWAKE = 2'd0,
        PH_REQ   = 2'd1,
        PH_DOWN  = 2'd2,
        PH_WAKE  = 2'd3
    } phase_e;

endpackage

// File: rtl/slpw_sync.sv
module slpw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/slpw_cpu_fsm.sv
module slpw_cpu_fsm
    import slpw_pkg::*;
(
    input  logic    cpu_clk,
    input  logic    rst_n,
    input  logic    sleep_wr,
    input  logic    bus_ack,
    input  logic    wake_irq,
    input  logic    rel_done,
    output cpu_st_e cst,
    output logic    pd_fast
);
    cpu_st_e cst_nx;

    // state register
    always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) cst <= C_AWAKE;
        else        cst <= cst_nx;
    end

    // transitions
    always_comb begin
        cst_nx = cst;
        unique case (cst)
            C_AWAKE: if (sleep_wr) cst_nx = C_REQ;
            C_REQ: begin
                if (wake_irq)     cst_nx = C_AWAKE;   // cancel wins over grant
                else if (bus_ack) cst_nx = C_DOWN;
            end
            C_DOWN:  if (rel_done) cst_nx = C_AWAKE;
            default: cst_nx = C_AWAKE;
        endcase
    end

    // power-down launched on the falling edge after the grant
    always_ff @(negedge cpu_clk or negedge rst_n) begin
        if (!rst_n) pd_fast <= 1'b0;
        else        pd_fast <= (cst == C_DOWN);
    end
endmodule

// File: rtl/slpw_slow_fsm.sv
module slpw_slow_fsm
    import slpw_pkg::*;
(
    input  logic     slow_clk,
    input  logic     rst_n,
    input  logic     pd_req,
    input  logic     irq_hit,
    output slow_st_e sst,
    output logic     rel_flag,
    output logic     sup_sample,
    output logic     pd_released
);
    slow_st_e sst_nx;
    logic     irq_cap;

    // state register, rising edges
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) sst <= S_IDLE;
        else        sst <= sst_nx;
    end

    always_comb begin
        sst_nx = sst;
        unique case (sst)
            S_IDLE:   if (pd_req)  sst_nx = S_ASLEEP;
            S_ASLEEP: if (irq_cap) sst_nx = S_PWRUP;
            S_PWRUP:  sst_nx = S_SAMPLE;
            S_SAMPLE: sst_nx = S_DONE;
            S_DONE:   if (!pd_req) sst_nx = S_IDLE;
            default:  sst_nx = S_IDLE;
        endcase
    end

    // falling-edge steps: interrupt capture and bus release
    always_ff @(negedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_cap  <= 1'b0;
            rel_flag <= 1'b0;
        end else begin
            irq_cap <= (sst == S_ASLEEP) && irq_hit;
            if (sst == S_SAMPLE)    rel_flag <= 1'b1;
            else if (sst == S_IDLE) rel_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sup_sample  = (sst == S_SAMPLE);
        pd_released = (sst == S_PWRUP) || (sst == S_SAMPLE) || (sst == S_DONE);
    end
endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
    import slpw_pkg::*;
#(
    parameter int N_IRQ     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             cpu_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             sleep_wr,
    input  logic             bus_ack,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             bus_req,
    output logic             pwr_dn,
    output logic             sup_sample,
    output logic             sleep_bit,
    output logic [1:0]       phase
);
    cpu_st_e  cst;
    slow_st_e sst;
    logic     any_irq, irq_s, rel_flag, rel_s, pd_fast, pd_s, pd_released;

    assign any_irq = |(irq_pend & irq_en);

    slpw_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_irq_sync (
        .clk(cpu_clk), .rst_n(rst_n), .d(any_irq), .q(irq_s));

    slpw_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_rel_sync (
        .clk(cpu_clk), .rst_n(rst_n), .d(rel_flag), .q(rel_s));

    slpw_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_pd_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(pd_fast), .q(pd_s));

    slpw_cpu_fsm u_cpu (
        .cpu_clk(cpu_clk), .rst_n(rst_n), .sleep_wr(sleep_wr),
        .bus_ack(bus_ack), .wake_irq(irq_s), .rel_done(rel_s),
        .cst(cst), .pd_fast(pd_fast));

    slpw_slow_fsm u_slow (
        .slow_clk(slow_clk), .rst_n(rst_n), .pd_req(pd_s),
        .irq_hit(any_irq), .sst(sst), .rel_flag(rel_flag),
        .sup_sample(sup_sample), .pd_released(pd_released));

    // outputs
    always_comb begin
        bus_req   = (cst == C_AWAKE && sleep_wr) || (cst == C_REQ) ||
                    (cst == C_DOWN && !rel_flag);
        pwr_dn    = pd_fast && !pd_released;
        sleep_bit = (cst != C_AWAKE);
        if (cst == C_REQ || (cst == C_DOWN && !pd_fast)) phase = PH_REQ;
        else if (pwr_dn)                                 phase = PH_DOWN;
        else if (cst == C_DOWN)                          phase = PH_WAKE;
        else                                             phase = PH_AWAKE;
    end
endmodule

// File: rtl/slpw_chk.sv
module slpw_chk (
    input logic       cpu_clk,
    input logic       slow_clk,
    input logic       rst_n,
    input logic       sleep_wr,
    input logic       bus_ack,
    input logic       bus_req,
    input logic       pwr_dn,
    input logic       sup_sample,
    input logic [1:0] phase
);
    p_req_on_write_r1: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (sleep_wr && phase == 2'd0) |-> bus_req);

    p_pd_after_grant_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        pwr_dn |-> bus_ack);

    p_pd_under_req_r3: assert property (@(posedge slow_clk) disable iff (!rst_n)
        pwr_dn |-> bus_req);

    p_strobe_follows_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $fell(pwr_dn) |=> sup_sample);

    p_strobe_single_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        sup_sample |=> !sup_sample);

    p_release_in_strobe_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
        sup_sample |-> (!bus_req && !pwr_dn));

    p_phase_down_r10: assert property (@(posedge slow_clk) disable iff (!rst_n)
        pwr_dn |-> phase == 2'd2);
endmodule

bind slp_wake_seq slpw_chk u_chk (
    .cpu_clk(cpu_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .sleep_wr(sleep_wr), .bus_ack(bus_ack), .bus_req(bus_req),
    .pwr_dn(pwr_dn), .sup_sample(sup_sample), .phase(phase));

// File: tb/slp_wake_seq_tb_top.sv
module slp_wake_seq_tb_top;
    localparam int NI = 4;

    logic          cpu_clk, slow_clk, rst_n, sleep_wr, bus_ack;
    logic [NI-1:0] irq_pend, irq_en;
    logic          bus_req, pwr_dn, sup_sample, sleep_bit;
    logic [1:0]    phase;
    int            n_chk = 0, n_fail = 0;

    slp_wake_seq #(.N_IRQ(NI)) dut_i (
        .cpu_clk(cpu_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .sleep_wr(sleep_wr), .bus_ack(bus_ack), .irq_pend(irq_pend),
        .irq_en(irq_en), .bus_req(bus_req), .pwr_dn(pwr_dn),
        .sup_sample(sup_sample), .sleep_bit(sleep_bit), .phase(phase));

    // 125 MHz CPU clock, halted low while power is down
    initial begin
        cpu_clk = 1'b0;
        forever begin
            #4;
            if (!pwr_dn || cpu_clk) cpu_clk = ~cpu_clk;
        end
    end

    initial begin
        slow_clk = 1'b0;
        forever #40 slow_clk = ~slow_clk;
    end

    // CPU model: grant follows request one clock later
    always @(posedge cpu_clk or negedge rst_n)
        if (!rst_n) bus_ack <= 1'b0;
        else        bus_ack <= bus_req;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enter_sleep();
        @(negedge cpu_clk); sleep_wr = 1'b1;
        #1 chk("R1 bus_req on write", bus_req, 1);
        @(posedge cpu_clk); #1 sleep_wr = 1'b0;
        chk("R10 phase requesting", phase, 1);
        chk("R2 no power-down before grant", pwr_dn, 0);
        @(posedge cpu_clk); #1
        chk("R2 pwr_dn low after grant edge", pwr_dn, 0);
        chk("R2 grant seen", bus_ack, 1);
        @(negedge cpu_clk); #1
        chk("R2 pwr_dn on falling edge", pwr_dn, 1);
        chk("R10 phase down", phase, 2);
        chk("R3 bus_req held", bus_req, 1);
    endtask

    // called 5 ns after a slow rising edge with the wake interrupt applied
    task automatic wake_seq();
        @(negedge slow_clk); #2
        chk("R5 pwr_dn held at capture", pwr_dn, 1);
        @(posedge slow_clk); #2
        chk("R5 pwr_dn released", pwr_dn, 0);
        chk("R6 no strobe yet", sup_sample, 0);
        chk("R10 phase waking", phase, 3);
        @(posedge slow_clk); #2
        chk("R6 strobe up", sup_sample, 1);
        chk("R7 bus still requested", bus_req, 1);
        @(negedge slow_clk); #2
        chk("R7 bus released", bus_req, 0);
        chk("R7 pwr_dn low", pwr_dn, 0);
        @(posedge slow_clk); #2
        chk("R6 strobe one period", sup_sample, 0);
        repeat (8) @(posedge cpu_clk);
        #1
        chk("R8 sleep bit cleared", sleep_bit, 0);
        chk("R8 phase awake", phase, 0);
        chk("R8 grant dropped", bus_ack, 0);
    endtask

    initial begin
        rst_n = 1'b0; sleep_wr = 1'b0; irq_pend = '0; irq_en = '0;
        #2;
        chk("R11 bus_req reset", bus_req, 0);
        chk("R11 pwr_dn reset", pwr_dn, 0);
        chk("R11 sup_sample reset", sup_sample, 0);
        chk("R11 sleep_bit reset", sleep_bit, 0);
        chk("R11 phase reset", phase, 0);
        #101 rst_n = 1'b1;
        repeat (4) @(posedge cpu_clk);

        // R9: cancel by each unmasked line before grant
        for (int i = 0; i < NI; i++) begin
            @(negedge cpu_clk);
            irq_en = NI'(1) << i; irq_pend = NI'(1) << i;
            repeat (4) @(posedge cpu_clk);
            @(negedge cpu_clk); sleep_wr = 1'b1;
            #1 chk("R1 bus_req on write", bus_req, 1);
            @(posedge cpu_clk); #1 sleep_wr = 1'b0;
            @(posedge cpu_clk); #1
            chk("R9 cancel drops bus_req", bus_req, 0);
            chk("R9 cancel clears sleep", sleep_bit, 0);
            chk("R9 cancel phase awake", phase, 0);
            repeat (6) @(posedge cpu_clk);
            #1
            chk("R9 no power-down", pwr_dn, 0);
            chk("R9 grant dropped", bus_ack, 0);
            irq_pend = '0; irq_en = '0;
            repeat (4) @(posedge cpu_clk);
        end

        // R4: sweep every enable and pending combination
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                enter_sleep();
                repeat (4) @(posedge slow_clk);
                #5 irq_en = NI'(e); irq_pend = NI'(p);
                if ((e & p) != 0) begin
                    wake_seq();
                end else begin
                    repeat (3) @(posedge slow_clk);
                    #2 chk("R4 masked stays down", pwr_dn, 1);
                    chk("R4 phase down", phase, 2);
                    #3 irq_en = '1; irq_pend = NI'(1);
                    wake_seq();
                end
                irq_pend = '0; irq_en = '0;
                repeat (4) @(posedge slow_clk);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule